// File: doc/BRIEF.md
# Subroutine Call and Return Link Sequencer

This unit produces the stack traffic for the four subroutine linkage operations of an 8-bit-datapath processor with a banked 16-bit program counter: a short call, a long call that also records the program bank, and the two matching returns. When the instruction sequencer presents one of those opcodes together with the address of the opcode byte, the current bank and the stack pointer, the unit takes over for the rest of the instruction. It emits one stack byte access per cycle: writes for calls, reads for returns. At the end it reports the final stack pointer and, for returns, the new program counter and bank.

The linkage address is deliberately one short of the instruction that follows the call. A short call records the address of its own third byte. A long call records the address of its fourth byte plus the bank. The returns add one to the pulled address, and that addition wraps inside 16 bits without touching the bank. In emulation mode the stack stays in page one: the pointer's high byte is held at 01 and only the low byte wraps.

The stack read port is assumed to answer in the same cycle that `pull_re` is high, and the unit samples `pull_data` at the end of that cycle. Operand fetch, memory wait states and interrupts belong to other blocks.

Top module: `subr_link_unit`

## Requirements
- R1: After reset the unit is idle with every strobe low. When `start` is high in an idle cycle with opcode 20h, 22h, 60h or 6Bh, the instruction takes 6, 8, 6 or 6 cycles respectively, counting the `start` cycle. `busy` is high for all later cycles of the instruction, and `done` and `sp_we` are high only in its last cycle.
- R2: Opcode 20h pushes two bytes, high byte then low byte, of (opcode address + 2) mod 2^16.
- R3: Opcode 22h pushes three bytes in the order bank, high, low, where the address is (opcode address + 3) mod 2^16.
- R4: Each push writes at the current stack pointer and then decrements it. The final `sp_out` of a call is the entry pointer minus the number of bytes pushed.
- R5: Each pull first increments the stack pointer and then reads at the new value, so the address low byte is read first, then the high byte, then (long form) the bank. The final `sp_out` of a return is the entry pointer plus the number of bytes pulled.
- R6: Opcode 60h reports `new_pc` = (pulled address + 1) mod 2^16 with `pc_we` high in the last cycle, and leaves `bank_we` low.
- R7: Opcode 6Bh reports `new_pc` the same way and also `new_bank` = the third pulled byte with `bank_we` high. An address of FFFFh returns 0000h with the bank unchanged (no carry into the bank).
- R8: With `emu` high at `start`, the entry pointer's high byte is replaced by 01h, and every stack address and the final pointer keep high byte 01h with the low byte wrapping.
- R9: `start` is ignored in any cycle where `busy` is high, including the last cycle, and when the opcode is not one of the four. An ignored start changes no output.
- R10: Calls push in the last 2 (short) or 3 (long) cycles of the instruction. Returns pull in the 2 or 3 cycles just before the last cycle. `push_we` and `pull_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode presented, unit may take over |
| opcode | input | 8 | Opcode of the current instruction |
| inst_addr | input | 16 | Address of the opcode byte |
| inst_bank | input | 8 | Current program bank |
| sp_in | input | 16 | Stack pointer at instruction start |
| emu | input | 1 | Emulation mode, stack confined to page one |
| pull_data | input | 8 | Stack read data for the current cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| push_we | output | 1 | Stack write strobe |
| pull_re | output | 1 | Stack read strobe |
| stk_addr | output | 16 | Stack byte address for the access |
| push_data | output | 8 | Byte to write |
| sp_we | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | 16 | Updated stack pointer |
| pc_we | output | 1 | Load `new_pc` (returns only) |
| new_pc | output | 16 | Program counter after a return |
| bank_we | output | 1 | Load `new_bank` (long return only) |
| new_bank | output | 8 | Program bank after a long return |

## Verification
The assertions check, on every cycle, the rules that depend only on the current cycle or the one before it. A read and a write never share a cycle. `done` ends an in-flight instruction. Back-to-back pushes step the address down by one and back-to-back pulls step it up by one. Emulation-mode accesses stay in page one. A bank load only comes with a program counter load.

Only the bench's scenarios can show the values themselves. These are the exact byte order and content of the linkage address, the cycle counts of each opcode, and the return arithmetic at the FFFFh wrap. Two further behaviours also need a scenario: a call followed by its return lands one past the call instruction, and starts issued during an instruction are dropped.

// File: rtl/subr_link_pkg.sv
package subr_link_pkg;

  typedef enum logic [2:0] {
    LK_NONE  = 3'd0,
    LK_CALL  = 3'd1,
    LK_LCALL = 3'd2,
    LK_RET   = 3'd3,
    LK_LRET  = 3'd4
  } link_kind_e;

  function automatic logic kind_is_call(input link_kind_e k);
    return (k == LK_CALL) || (k == LK_LCALL);
  endfunction

  function automatic logic kind_is_long(input link_kind_e k);
    return (k == LK_LCALL) || (k == LK_LRET);
  endfunction

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/subr_link_decode.sv
module subr_link_decode
  import subr_link_pkg::*;
#(
  parameter logic [7:0] OP_CALL   = 8'h20,
  parameter logic [7:0] OP_LCALL  = 8'h22,
  parameter logic [7:0] OP_RET    = 8'h60,
  parameter logic [7:0] OP_LRET   = 8'h6B,
  parameter int         CYC_CALL  = 6,
  parameter int         CYC_LCALL = 8,
  parameter int         CYC_RET   = 6,
  parameter int         CYC_LRET  = 6,
  parameter int         ADDR_BYTES = 2,
  parameter int         CNT_W     = 4,
  parameter int         POS_W     = 2
) (
  input  logic [7:0]       opcode,
  output logic             valid,
  output link_kind_e       kind,
  output logic [POS_W-1:0] nbytes,
  output logic [CNT_W-1:0] ncyc
);

  localparam logic [POS_W-1:0] NB_SHORT = POS_W'(ADDR_BYTES);
  localparam logic [POS_W-1:0] NB_LONG  = POS_W'(ADDR_BYTES + 1);

  always_comb begin
    valid  = 1'b1;
    kind   = LK_NONE;
    nbytes = NB_SHORT;
    ncyc   = '0;
    case (opcode)
      OP_CALL: begin
        kind = LK_CALL;
        ncyc = CNT_W'(CYC_CALL);
      end
      OP_LCALL: begin
        kind   = LK_LCALL;
        nbytes = NB_LONG;
        ncyc   = CNT_W'(CYC_LCALL);
      end
      OP_RET: begin
        kind = LK_RET;
        ncyc = CNT_W'(CYC_RET);
      end
      OP_LRET: begin
        kind   = LK_LRET;
        nbytes = NB_LONG;
        ncyc   = CNT_W'(CYC_LRET);
      end
      default: valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/subr_link_sp.sv
module subr_link_sp #(
  parameter int SP_W     = 16,
  parameter int PAGE_W   = 8,
  parameter int EMU_PAGE = 1
) (
  input  logic [SP_W-1:0] sp_raw,
  input  logic [SP_W-1:0] sp_q,
  input  logic            emu_raw,
  input  logic            emu_q,
  output logic [SP_W-1:0] sp_entry,
  output logic [SP_W-1:0] sp_dn,
  output logic [SP_W-1:0] sp_up
);

  generate
    if (SP_W > PAGE_W) begin : g_paged
      localparam int HI_W = SP_W - PAGE_W;
      localparam logic [HI_W-1:0] PAGE = HI_W'(EMU_PAGE);
      logic [PAGE_W-1:0] lo_dn, lo_up;
      assign lo_dn    = sp_q[PAGE_W-1:0] - PAGE_W'(1);
      assign lo_up    = sp_q[PAGE_W-1:0] + PAGE_W'(1);
      assign sp_entry = emu_raw ? {PAGE, sp_raw[PAGE_W-1:0]} : sp_raw;
      assign sp_dn    = emu_q ? {PAGE, lo_dn} : sp_q - SP_W'(1);
      assign sp_up    = emu_q ? {PAGE, lo_up} : sp_q + SP_W'(1);
    end else begin : g_flat
      logic unused_emu;
      assign unused_emu = emu_raw ^ emu_q;
      assign sp_entry   = sp_raw;
      assign sp_dn      = sp_q - SP_W'(1);
      assign sp_up      = sp_q + SP_W'(1);
    end
  endgenerate

endmodule

// File: rtl/subr_link_bytesel.sv
module subr_link_bytesel #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int POS_W  = 2
) (
  input  logic [ADDR_W-1:0] link_addr,
  input  logic [DATA_W-1:0] link_bank,
  input  logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] byte_o
);

  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int NLANE      = ADDR_BYTES + 1;

  logic [DATA_W-1:0] lane [NLANE];

  generate
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
      assign lane[g] = link_addr[g*DATA_W +: DATA_W];
    end
  endgenerate
  assign lane[ADDR_BYTES] = link_bank;

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (int'(pos) == i) byte_o = lane[i];
    end
  end

endmodule

// File: rtl/subr_link_unit.sv
module subr_link_unit
  import subr_link_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         DATA_W    = 8,
  parameter int         SP_W      = 16,
  parameter int         EMU_PAGE  = 1,
  parameter logic [7:0] OP_CALL   = 8'h20,
  parameter logic [7:0] OP_LCALL  = 8'h22,
  parameter logic [7:0] OP_RET    = 8'h60,
  parameter logic [7:0] OP_LRET   = 8'h6B,
  parameter int         CYC_CALL  = 6,
  parameter int         CYC_LCALL = 8,
  parameter int         CYC_RET   = 6,
  parameter int         CYC_LRET  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] inst_addr,
  input  logic [DATA_W-1:0] inst_bank,
  input  logic [SP_W-1:0]   sp_in,
  input  logic              emu,
  input  logic [DATA_W-1:0] pull_data,
  output logic              busy,
  output logic              done,
  output logic              push_we,
  output logic              pull_re,
  output logic [SP_W-1:0]   stk_addr,
  output logic [DATA_W-1:0] push_data,
  output logic              sp_we,
  output logic [SP_W-1:0]   sp_out,
  output logic              pc_we,
  output logic [ADDR_W-1:0] new_pc,
  output logic              bank_we,
  output logic [DATA_W-1:0] new_bank
);

  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int MAX_BYTES  = ADDR_BYTES + 1;
  localparam int CYC_MAX    = max_of4(CYC_CALL, CYC_LCALL, CYC_RET, CYC_LRET);
  localparam int CNT_W      = $clog2(CYC_MAX + 1);
  localparam int POS_W      = $clog2(MAX_BYTES + 1);

  // decode of the presented opcode
  logic             dec_valid;
  link_kind_e       dec_kind;
  logic [POS_W-1:0] dec_nb;
  logic [CNT_W-1:0] dec_ncyc;

  subr_link_decode #(
    .OP_CALL(OP_CALL), .OP_LCALL(OP_LCALL), .OP_RET(OP_RET), .OP_LRET(OP_LRET),
    .CYC_CALL(CYC_CALL), .CYC_LCALL(CYC_LCALL), .CYC_RET(CYC_RET), .CYC_LRET(CYC_LRET),
    .ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .POS_W(POS_W)
  ) u_dec (
    .opcode(opcode),
    .valid (dec_valid),
    .kind  (dec_kind),
    .nbytes(dec_nb),
    .ncyc  (dec_ncyc)
  );

  // instruction state
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  link_kind_e        kind_q;
  logic [CNT_W-1:0]  ncyc_q;
  logic [POS_W-1:0]  nb_q;
  logic              emu_q;
  logic [SP_W-1:0]   sp_q;
  logic [ADDR_W-1:0] link_q;
  logic [DATA_W-1:0] bank_q;
  logic [DATA_W-1:0] pulled_q [MAX_BYTES];

  // named internal events
  logic              accept;
  logic              is_call;
  logic              is_long;
  logic [CNT_W-1:0]  first_op;
  logic              in_window;
  logic [CNT_W-1:0]  idx;
  logic [POS_W-1:0]  pos;
  logic              last_cyc;
  logic [SP_W-1:0]   sp_entry, sp_dn, sp_up, sp_nxt;
  logic [ADDR_W-1:0] link_calc;
  logic [ADDR_W-1:0] pulled_addr;
  logic [DATA_W-1:0] sel_byte;

  assign accept   = start && !busy_q && dec_valid;
  assign is_call  = kind_is_call(kind_q);
  assign is_long  = kind_is_long(kind_q);
  assign last_cyc = busy_q && (cnt_q == ncyc_q);

  // calls end on their last push; returns need one cycle after the last pull
  assign first_op  = ncyc_q - CNT_W'(nb_q) + (is_call ? CNT_W'(1) : CNT_W'(0));
  assign in_window = busy_q && (cnt_q >= first_op) && (is_call || !last_cyc);
  assign idx       = cnt_q - first_op;
  assign pos       = is_call ? (nb_q - POS_W'(1) - POS_W'(idx)) : POS_W'(idx);

  subr_link_sp #(
    .SP_W(SP_W), .PAGE_W(8), .EMU_PAGE(EMU_PAGE)
  ) u_sp (
    .sp_raw  (sp_in),
    .sp_q    (sp_q),
    .emu_raw (emu),
    .emu_q   (emu_q),
    .sp_entry(sp_entry),
    .sp_dn   (sp_dn),
    .sp_up   (sp_up)
  );

  subr_link_bytesel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W)
  ) u_sel (
    .link_addr(link_q),
    .link_bank(bank_q),
    .pos      (pos),
    .byte_o   (sel_byte)
  );

  // linkage address: last byte of the call instruction
  assign link_calc = inst_addr + ADDR_W'(kind_is_long(dec_kind) ? ADDR_BYTES + 1 : ADDR_BYTES);

  generate
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_pull
      assign pulled_addr[g*DATA_W +: DATA_W] = pulled_q[g];
    end
  endgenerate

  always_comb begin
    if (push_we)      sp_nxt = sp_dn;
    else if (pull_re) sp_nxt = sp_up;
    else              sp_nxt = sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= LK_NONE;
      ncyc_q <= '0;
      nb_q   <= '0;
      emu_q  <= 1'b0;
      sp_q   <= '0;
      link_q <= '0;
      bank_q <= '0;
      for (int i = 0; i < MAX_BYTES; i++) pulled_q[i] <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(2);
        kind_q <= dec_kind;
        ncyc_q <= dec_ncyc;
        nb_q   <= dec_nb;
        emu_q  <= emu;
        sp_q   <= sp_entry;
        link_q <= link_calc;
        bank_q <= inst_bank;
      end else if (busy_q) begin
        sp_q <= sp_nxt;
        if (last_cyc) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      for (int i = 0; i < MAX_BYTES; i++) begin
        if (pull_re && (int'(pos) == i)) pulled_q[i] <= pull_data;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = last_cyc;
  assign push_we   = in_window && is_call;
  assign pull_re   = in_window && !is_call;
  assign stk_addr  = pull_re ? sp_up : (push_we ? sp_q : '0);
  assign push_data = push_we ? sel_byte : '0;
  assign sp_we     = last_cyc;
  assign sp_out    = busy_q ? sp_nxt : '0;
  assign pc_we     = last_cyc && !is_call;
  assign new_pc    = pc_we ? (pulled_addr + ADDR_W'(1)) : '0;
  assign bank_we   = last_cyc && (kind_q == LK_LRET);
  assign new_bank  = bank_we ? pulled_q[ADDR_BYTES] : '0;

endmodule

// File: rtl/subr_link_chk.sv
module subr_link_chk #(
  parameter int SP_W     = 16,
  parameter int EMU_PAGE = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            push_we,
  input logic            pull_re,
  input logic [SP_W-1:0] stk_addr,
  input logic            pc_we,
  input logic            bank_we,
  input logic            emu_q
);

  // R10
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_we && pull_re));

  // R1
  done_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R1
  done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_we && $past(push_we) && !emu_q) |-> (stk_addr == $past(stk_addr) - SP_W'(1)));

  // R5
  pull_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_re && $past(pull_re) && !emu_q) |-> (stk_addr == $past(stk_addr) + SP_W'(1)));

  // R8
  emu_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((push_we || pull_re) && emu_q) |-> (stk_addr[SP_W-1:8] == (SP_W-8)'(EMU_PAGE)));

  // R6
  pc_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> done);

  // R7
  bank_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> pc_we);

endmodule

bind subr_link_unit subr_link_chk #(.SP_W(SP_W), .EMU_PAGE(EMU_PAGE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .push_we (push_we),
  .pull_re (pull_re),
  .stk_addr(stk_addr),
  .pc_we   (pc_we),
  .bank_we (bank_we),
  .emu_q   (emu_q)
);

// File: tb/subr_link_unit_tb.sv
`timescale 1ns/1ps
module subr_link_unit_tb;

  localparam real HALF = 4.0; // 125 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] inst_addr = '0;
  logic [7:0]  inst_bank = '0;
  logic [15:0] sp_in = '0;
  logic        emu = 1'b0;
  logic [7:0]  pull_data = '0;
  logic        busy, done, push_we, pull_re, sp_we, pc_we, bank_we;
  logic [15:0] stk_addr, sp_out, new_pc;
  logic [7:0]  push_data, new_bank;

  always #(HALF) clk = ~clk;

  subr_link_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .inst_addr(inst_addr), .inst_bank(inst_bank), .sp_in(sp_in), .emu(emu),
    .pull_data(pull_data), .busy(busy), .done(done), .push_we(push_we),
    .pull_re(pull_re), .stk_addr(stk_addr), .push_data(push_data),
    .sp_we(sp_we), .sp_out(sp_out), .pc_we(pc_we), .new_pc(new_pc),
    .bank_we(bank_we), .new_bank(new_bank)
  );

  typedef struct {
    bit          busy, done, we, re, pcw, bkw, ign, emu, lng, call;
    logic [15:0] addr, sp, pc;
    logic [7:0]  wd, bk;
  } exp_t;

  exp_t        expq[$];
  logic [7:0]  mem [int];
  int          vectors = 0;
  int          fails = 0;
  bit          ign_idle = 0;
  bit          finished = 0;
  logic [15:0] last_pc = '0;
  logic [7:0]  last_bank = '0;

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  function automatic logic [15:0] step(input logic [15:0] s, input bit e, input int d);
    logic [7:0] lo;
    if (e) begin
      lo = s[7:0] + 8'(d);
      return {8'h01, lo};
    end
    return s + 16'(d);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // one clock: compare at the falling edge, then model the stack memory
  task automatic tick();
    exp_t e;
    string tt, ts, ta, td, tp;
    @(negedge clk);
    if (expq.size() > 0) e = expq.pop_front();
    else begin
      e = '{default: 0};
      e.ign = ign_idle;
    end
    tt = e.ign ? "R9" : "R1";
    ts = e.ign ? "R9" : "R10";
    ta = e.emu ? "R8" : (e.call ? "R4" : "R5");
    td = e.lng ? "R3" : "R2";
    tp = e.lng ? "R7" : "R6";
    chk(tt, "busy", int'(busy), int'(e.busy));
    chk(tt, "done", int'(done), int'(e.done));
    chk(tt, "sp_we", int'(sp_we), int'(e.done));
    chk(ts, "push_we", int'(push_we), int'(e.we));
    chk(ts, "pull_re", int'(pull_re), int'(e.re));
    if (e.we || e.re) chk(ta, "stk_addr", int'(stk_addr), int'(e.addr));
    if (e.we) chk(td, "push_data", int'(push_data), int'(e.wd));
    if (e.done) chk(ta, "sp_out", int'(sp_out), int'(e.sp));
    chk(tp, "pc_we", int'(pc_we), int'(e.pcw));
    chk("R7", "bank_we", int'(bank_we), int'(e.bkw));
    if (e.pcw) begin
      chk(tp, "new_pc", int'(new_pc), int'(e.pc));
      last_pc = new_pc;
    end
    if (e.bkw) begin
      chk("R7", "new_bank", int'(new_bank), int'(e.bk));
      last_bank = new_bank;
    end
    if (push_we) mem[int'(stk_addr)] = push_data;
    pull_data = pull_re ? rd(stk_addr) : 8'h00;
    start = 1'b0;
  endtask

  // issue one instruction and queue the expected behaviour of every later cycle
  task automatic run_op(input logic [7:0] op, input logic [15:0] a, input logic [7:0] bk,
                        input logic [15:0] sp, input bit e, input bit poke);
    int          n, nb, first;
    bit          call, lng;
    logic [15:0] s, link;
    logic [7:0]  bytes [3];
    exp_t        r;
    call = (op == 8'h20) || (op == 8'h22);
    lng  = (op == 8'h22) || (op == 8'h6B);
    n    = (op == 8'h22) ? 8 : 6;          // R1 cycle counts
    nb   = lng ? 3 : 2;
    s    = e ? {8'h01, sp[7:0]} : sp;      // R8 entry into page one
    link = a + (lng ? 16'd3 : 16'd2);      // R2 R3 linkage address
    start = 1'b1; opcode = op; inst_addr = a; inst_bank = bk; sp_in = sp; emu = e;
    first = call ? n - nb + 1 : n - nb;
    bytes[0] = 8'h00; bytes[1] = 8'h00; bytes[2] = 8'h00;
    for (int c = 2; c <= n; c++) begin
      r = '{default: 0};
      r.busy = 1; r.emu = e; r.lng = lng; r.call = call;
      r.ign = poke && (c >= 4);
      if (call && c >= first) begin
        // R4 write then step down; R2/R3 order bank, high, low
        int p;
        p = nb - 1 - (c - first);
        r.we = 1; r.addr = s;
        r.wd = (p == 2) ? bk : (p == 1 ? link[15:8] : link[7:0]);
        s = step(s, e, -1);
      end
      if (!call && c >= first && c < n) begin
        // R5 step up then read, low byte first
        s = step(s, e, 1);
        r.re = 1; r.addr = s;
        bytes[c - first] = rd(s);
      end
      if (c == n) begin
        r.done = 1; r.sp = s;
        if (!call) begin
          r.pcw = 1; r.pc = {bytes[1], bytes[0]} + 16'd1;   // R6 wraps in 16 bits
          r.bkw = lng; r.bk = bytes[2];                     // R7 bank restored
        end
      end
      expq.push_back(r);
    end
    for (int c = 2; c <= n; c++) begin
      tick();
      if (poke && (c == 3)) begin
        start = 1'b1; opcode = 8'h22; inst_addr = 16'h5555; sp_in = 16'h0AAA;
      end
      if (poke && (c == n - 1)) begin
        start = 1'b1; opcode = 8'h60;      // lands in the last cycle: R9
      end
    end
    tick();
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset strobes", int'({push_we, pull_re, pc_we, bank_we, sp_we}), 0);

    // R2 R4 short call, R6 R5 its return
    run_op(8'h20, 16'h1234, 8'h05, 16'h01FF, 0, 0);
    run_op(8'h60, 16'h9000, 8'h05, 16'h01FD, 0, 0);
    chk("R6", "round trip", int'(last_pc), 16'h1237);

    // R3 long call and R7 long return
    run_op(8'h22, 16'hABCD, 8'h7E, 16'h3000, 0, 0);
    run_op(8'h6B, 16'h0010, 8'h00, 16'h2FFD, 0, 0);
    chk("R7", "long round trip pc", int'(last_pc), 16'hABD1);
    chk("R7", "long round trip bank", int'(last_bank), 8'h7E);

    // R2 linkage address wraps at the top of the bank
    run_op(8'h20, 16'hFFFE, 8'h01, 16'h0800, 0, 0);
    run_op(8'h60, 16'h0000, 8'h01, 16'h07FE, 0, 0);
    chk("R6", "wrapped return", int'(last_pc), 16'h0001);

    // R7 no carry into the bank
    mem[16'h4001] = 8'hFF; mem[16'h4002] = 8'hFF; mem[16'h4003] = 8'h33;
    run_op(8'h6B, 16'h2000, 8'h44, 16'h4000, 0, 0);
    chk("R7", "carry pc", int'(last_pc), 16'h0000);
    chk("R7", "carry bank", int'(last_bank), 8'h33);

    // R8 emulation: page one, low byte wraps both ways
    run_op(8'h22, 16'h0300, 8'h12, 16'h0101, 1, 0);
    run_op(8'h6B, 16'h0400, 8'h00, 16'h01FE, 1, 0);
    chk("R8", "emu round trip", int'(last_pc), 16'h0304);
    run_op(8'h20, 16'h0600, 8'h00, 16'h2345, 1, 0);

    // R9 unknown opcode while idle
    ign_idle = 1;
    start = 1'b1; opcode = 8'hEA; inst_addr = 16'h1111; sp_in = 16'h0300;
    tick();
    tick();
    // R9 starts during an instruction, R10 ordering still holds
    run_op(8'h20, 16'h7000, 8'h02, 16'h0500, 0, 1);
    tick();
    tick();
    ign_idle = 0;
    run_op(8'h60, 16'h0000, 8'h02, 16'h04FE, 0, 0);
    chk("R6", "after ignored starts", int'(last_pc), 16'h7003);

    for (int i = 0; i < 4; i++) tick();
    summary();
  end

endmodule